// File: doc/BRIEF.md
# Weighted Score Accumulator with Temporal and Spatial Datapaths

The block forms a weighted total of four 8-bit unsigned scores: two midterm scores, a homework score and a project score. The weights are one tenth, two tenths, three tenths and four tenths. The weights are held as unsigned fractions with eight fraction bits. Because the four fixed-point weights add up to exactly one, the full-precision sum always fits in 16 bits. The output is that sum truncated back to an 8-bit score.

Two datapaths compute the same value, and a mode input chooses between them when a run starts. The temporal datapath owns one multiplier and one adder. It steps through the four terms in a fixed order, taking a multiply cycle and then an add cycle for each term. It clears its accumulator before it adds the first term. The spatial datapath has four multipliers and an adder tree. It produces the total in the cycle after start. A caller pulses `start` with the scores and the mode, then waits for `done`. The result register keeps its value until the next run completes.

Top module: `wsum_acc`

## Requirements
- R1: The result equals floor((26·m1 + 51·m2 + 77·hw + 102·pj) / 256). The weights are the unsigned Q0.8 constants 26, 51, 77 and 102, and the scores are unsigned 8-bit values. All four scores at 255 give 255, and all four at 1 give 1.
- R2: When `mode_spatial` is 1, a start sampled at a clock edge makes `done` high and places the result on `result` in the cycle right after the start cycle.
- R3: When `mode_spatial` is 0, a start begins eight work cycles, one multiply cycle and one add cycle for each term. `done` and the result appear in the ninth cycle after the start cycle.
- R4: Each temporal run clears its accumulator to zero before adding the first term, so a run started right after another run carries nothing over from it.
- R5: While a temporal run is in progress, a start is ignored in either mode. It produces no extra `done`, and it does not change the running result.
- R6: `done` is high only in the cycle after a run completes. `result` changes only in a cycle where `done` is high, and otherwise holds its last value.
- R7: While `rst` is high and after it is released, `result` reads 0 and `done` reads 0 until a run completes.
- R8: The mode is sampled only together with an accepted start. For equal scores, the two modes give equal results.
- R9: A temporal run captures the four scores in its start cycle. Changes on the score inputs during the run do not affect its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a run, sampled at the clock edge |
| mode_spatial | input | 1 | 1 selects the parallel datapath, 0 selects the stepped datapath |
| score_mid1 | input | 8 | First midterm score, weight 26/256 |
| score_mid2 | input | 8 | Second midterm score, weight 51/256 |
| score_hw | input | 8 | Homework score, weight 77/256 |
| score_proj | input | 8 | Project score, weight 102/256 |
| result | output | 8 | Truncated weighted total of the last completed run |
| done | output | 1 | High for the cycle in which a new result first appears |

## Verification
The assertions assume that `start` is a clean synchronous level sampled at the clock edge. They also assume that reset is held for at least two edges, so that the result register has a known value before the first check after reset. The bench drives every input on the falling edge, holds reset for several cycles and samples outputs shortly after the rising edge. It pulses `start` inside a temporal run in both modes and changes the scores during a run. These cases are legal input behaviour that the design must ignore, and the bench uses them to exercise the ignore paths without breaking the timing the assertions rely on.

// File: rtl/wsum_pkg.sv
package wsum_pkg;

    localparam int SCORE_W   = 8;
    localparam int WEIGHT_W  = 8;
    localparam int NUM_TERMS = 4;
    localparam int PROD_W    = SCORE_W + WEIGHT_W;
    localparam int ACC_W     = PROD_W + $clog2(NUM_TERMS);
    localparam int IDX_W     = $clog2(NUM_TERMS);
    localparam int STEPS     = 2 * NUM_TERMS;
    localparam int CNT_W     = $clog2(STEPS) + 1;

    typedef logic [SCORE_W-1:0]      score_t;
    typedef score_t [NUM_TERMS-1:0]  score_vec_t;
    typedef logic [WEIGHT_W-1:0]     weight_t;
    typedef logic [PROD_W-1:0]       prod_t;
    typedef logic [ACC_W-1:0]        acc_t;
    typedef logic [IDX_W-1:0]        idx_t;

    typedef enum logic {
        MODE_TEMPORAL = 1'b0,
        MODE_SPATIAL  = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_MUL  = 2'd1,
        SEQ_ADD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic   fin;
        score_t value;
    } finish_t;

    // Q0.8 weights; their sum is exactly 256.
    function automatic weight_t weight_of(input int idx);
        case (idx)
            0:       return weight_t'(26);
            1:       return weight_t'(51);
            2:       return weight_t'(77);
            default: return weight_t'(102);
        endcase
    endfunction

    // Drop the fraction bits, keeping a score-width integer.
    function automatic score_t scale_down(input acc_t a);
        return a[WEIGHT_W +: SCORE_W];
    endfunction

endpackage

// File: rtl/wsum_term_mul.sv
module wsum_term_mul
    import wsum_pkg::*;
(
    input  score_t  score,
    input  weight_t weight,
    output prod_t   product
);

    assign product = prod_t'(score) * prod_t'(weight);

endmodule

// File: rtl/wsum_seq_path.sv
module wsum_seq_path
    import wsum_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  score_vec_t scores,
    output logic       busy,
    output finish_t    fin
);

    seq_state_e state;
    idx_t       idx;
    score_vec_t held;
    prod_t      tmp;
    acc_t       acc;
    prod_t      prod;
    weight_t    w_sel;
    acc_t       acc_next;
    logic       last;

    assign w_sel    = weight_of(int'(idx));
    assign last     = (idx == idx_t'(NUM_TERMS - 1));
    assign acc_next = acc + acc_t'(tmp);
    assign busy     = (state != SEQ_IDLE);

    wsum_term_mul u_mul (
        .score   (held[idx]),
        .weight  (w_sel),
        .product (prod)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            idx   <= '0;
            held  <= '0;
            tmp   <= '0;
            acc   <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (go) begin
                        held  <= scores;
                        acc   <= '0;
                        idx   <= '0;
                        state <= SEQ_MUL;
                    end
                end
                SEQ_MUL: begin
                    tmp   <= prod;
                    state <= SEQ_ADD;
                end
                SEQ_ADD: begin
                    acc <= acc_next;
                    if (last) begin
                        state <= SEQ_IDLE;
                    end else begin
                        idx   <= idx + idx_t'(1);
                        state <= SEQ_MUL;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    always_comb begin
        fin.fin   = (state == SEQ_ADD) && last;
        fin.value = scale_down(acc_next);
    end

    // R4: an accepted start leaves an empty accumulator behind it
    assert_acc_cleared_R4: assert property (@(posedge clk) disable iff (rst)
        (go && !busy) |=> (acc == '0));

    // R9 / R5: captured scores do not move while a run is active
    assert_held_stable_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(held) || !busy);

    // R3: the final add returns the sequencer to idle
    assert_fin_to_idle_R3: assert property (@(posedge clk) disable iff (rst)
        fin.fin |=> (state == SEQ_IDLE));

endmodule

// File: rtl/wsum_par_path.sv
module wsum_par_path
    import wsum_pkg::*;
(
    input  logic       go,
    input  score_vec_t scores,
    output finish_t    fin
);

    localparam int NODES = 2 * NUM_TERMS;

    prod_t prods [NUM_TERMS];
    acc_t  node  [1:NODES-1];

    for (genvar i = 0; i < NUM_TERMS; i++) begin : g_mul
        wsum_term_mul u_mul (
            .score   (scores[i]),
            .weight  (weight_of(i)),
            .product (prods[i])
        );
        assign node[NUM_TERMS + i] = acc_t'(prods[i]);
    end

    // Heap-ordered adder tree: node k sums nodes 2k and 2k+1.
    for (genvar k = 1; k < NUM_TERMS; k++) begin : g_tree
        assign node[k] = node[2*k] + node[2*k+1];
    end

    always_comb begin
        fin.fin   = go;
        fin.value = scale_down(node[1]);
    end

endmodule

// File: rtl/wsum_acc.sv
module wsum_acc
    import wsum_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       mode_spatial,
    input  logic [7:0] score_mid1,
    input  logic [7:0] score_mid2,
    input  logic [7:0] score_hw,
    input  logic [7:0] score_proj,
    output logic [7:0] result,
    output logic       done
);

    mode_e      mode;
    score_vec_t scores;
    logic       seq_busy;
    logic       seq_go;
    logic       par_go;
    finish_t    seq_fin;
    finish_t    par_fin;
    score_t     result_q;
    logic       done_q;
    logic [CNT_W-1:0] since_go;

    assign mode      = mode_e'(mode_spatial);
    assign scores[0] = score_mid1;
    assign scores[1] = score_mid2;
    assign scores[2] = score_hw;
    assign scores[3] = score_proj;

    assign seq_go = start && (mode == MODE_TEMPORAL);
    assign par_go = start && (mode == MODE_SPATIAL) && !seq_busy;

    wsum_seq_path u_seq (
        .clk    (clk),
        .rst    (rst),
        .go     (seq_go),
        .scores (scores),
        .busy   (seq_busy),
        .fin    (seq_fin)
    );

    wsum_par_path u_par (
        .go     (par_go),
        .scores (scores),
        .fin    (par_fin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= seq_fin.fin || par_fin.fin;
            if (seq_fin.fin) begin
                result_q <= seq_fin.value;
            end else if (par_fin.fin) begin
                result_q <= par_fin.value;
            end
        end
    end

    assign result = result_q;
    assign done   = done_q;

    // Checker counter: cycles since a temporal start was accepted.
    always_ff @(posedge clk) begin
        if (rst) begin
            since_go <= '0;
        end else if (seq_go && !seq_busy) begin
            since_go <= CNT_W'(1);
        end else if (seq_fin.fin) begin
            since_go <= '0;
        end else if (since_go != '0) begin
            since_go <= since_go + CNT_W'(1);
        end
    end

    // R3: the final add lands on the eighth work cycle
    assert_seq_latency_R3: assert property (@(posedge clk) disable iff (rst)
        seq_fin.fin |-> (since_go == CNT_W'(STEPS)));

    // R2: a spatial start is answered on the next cycle
    assert_par_latency_R2: assert property (@(posedge clk) disable iff (rst)
        par_go |=> done);

    // R5: the two datapaths never complete together
    assert_single_source_R5: assert property (@(posedge clk) disable iff (rst)
        !(seq_fin.fin && par_fin.fin));

    // R6: the visible result only moves alongside done
    assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(result) |-> done);

endmodule

// File: tb/tb_wsum_acc.sv
module tb_wsum_acc;

    typedef struct {
        int    value;
        int    due;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       mode_spatial = 1'b0;
    logic [7:0] score_mid1 = '0;
    logic [7:0] score_mid2 = '0;
    logic [7:0] score_hw   = '0;
    logic [7:0] score_proj = '0;
    logic [7:0] result;
    logic       done;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    int   last_value = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    wsum_acc dut (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .mode_spatial (mode_spatial),
        .score_mid1   (score_mid1),
        .score_mid2   (score_mid2),
        .score_hw     (score_hw),
        .score_proj   (score_proj),
        .result       (result),
        .done         (done)
    );

    function automatic int model(input int a, input int b, input int c, input int d);
        return (26*a + 51*b + 77*c + 102*d) / 256;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Driver: one start pulse, expected item pushed to the scoreboard.
    task automatic launch(input bit sp, input int a, input int b, input int c,
                          input int d, input string tag);
        exp_t e;
        @(negedge clk);
        mode_spatial = sp;
        score_mid1 = 8'(a); score_mid2 = 8'(b);
        score_hw   = 8'(c); score_proj = 8'(d);
        start = 1'b1;
        e.value = model(a, b, c, d);
        e.due   = cyc + (sp ? 1 : 9);
        e.tag   = tag;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    // A start pulse that the design must drop: nothing is expected.
    task automatic stray_start(input bit sp, input int a);
        @(negedge clk);
        mode_spatial = sp;
        score_mid1 = 8'(a); score_mid2 = 8'(a);
        score_hw   = 8'(a); score_proj = 8'(a);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic hold_check(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #2;
            chk(done == 1'b0, "R6 done low while idle", int'(done), 0);
            chk(int'(result) == last_value, "R6 result holds", int'(result), last_value);
        end
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops scoreboard items as done appears.
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            if (done) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R5 unexpected done", int'(result), -1);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(result) == e.value, {e.tag, " value"}, int'(result), e.value);
                    chk(cyc == e.due, {e.tag, " latency"}, cyc, e.due);
                    last_value = e.value;
                end
            end else if (sb.size() != 0 && sb[0].due < cyc) begin
                exp_t e;
                e = sb.pop_front();
                chk(1'b0, {e.tag, " missing done"}, cyc, e.due);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R7: reset state, during and after reset
        chk(result == 8'd0, "R7 result in reset", int'(result), 0);
        chk(done == 1'b0, "R7 done in reset", int'(done), 0);
        rst = 1'b0;
        repeat (3) begin
            @(posedge clk); #2;
            chk(result == 8'd0 && done == 1'b0, "R7 idle after reset",
                int'({result, done}), 0);
        end

        // R2 / R1: spatial runs, single and back to back
        launch(1'b1, 10, 20, 30, 40, "R2 spatial");
        drain();
        launch(1'b1, 255, 255, 255, 255, "R1 all max spatial");
        launch(1'b1, 1, 1, 1, 1, "R1 all ones spatial");
        launch(1'b1, 0, 0, 0, 255, "R1 project only spatial");
        drain();
        hold_check(4);

        // R3 / R1: temporal runs
        launch(1'b0, 200, 150, 100, 50, "R3 temporal");
        drain();
        launch(1'b0, 255, 255, 255, 255, "R1 all max temporal");
        drain();
        launch(1'b0, 1, 1, 1, 1, "R1 all ones temporal");
        drain();
        hold_check(3);

        // R8: same scores in both modes
        launch(1'b0, 93, 17, 240, 131, "R8 temporal leg");
        drain();
        launch(1'b1, 93, 17, 240, 131, "R8 spatial leg");
        drain();

        // R4: a temporal start in the done cycle of the previous run
        launch(1'b0, 250, 240, 230, 220, "R4 first run");
        repeat (7) @(negedge clk);
        launch(1'b0, 0, 0, 0, 0, "R4 cleared run");
        drain();

        // R5: starts during a temporal run, both modes, are dropped
        launch(1'b0, 60, 70, 80, 90, "R5 run under stray starts");
        stray_start(1'b1, 255);
        stray_start(1'b0, 200);
        stray_start(1'b1, 3);
        drain();
        repeat (4) @(negedge clk);
        chk(sb.size() == 0, "R5 no stray result", sb.size(), 0);

        // R9: inputs change mid-run, result follows the captured scores
        launch(1'b0, 12, 34, 56, 78, "R9 captured scores");
        @(negedge clk);
        score_mid1 = 8'd255; score_mid2 = 8'd255;
        score_hw   = 8'd255; score_proj = 8'd255;
        drain();
        hold_check(3);

        chk(sb.size() == 0, "R6 scoreboard empty", sb.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog expired", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule